// File: doc/BRIEF.md
# Periodic Tick Timer

The block is a 24-bit down counter that software uses as a regular heartbeat, for example to time slices in a scheduler. Four word registers sit on a plain 32-bit register bus: a control word, a reload value, the live count and a fixed calibration word. While the timer runs, each tick lowers the count by one. A tick from zero loads the reload value instead, so the period is the reload value plus one ticks.

Ticks come either from every core clock cycle or from a one-cycle enable that a 3-bit prescaler raises once in eight cycles. When the count steps from one to zero, a sticky wrap flag is set. If interrupts are enabled, a one-cycle request pulse is also raised. Reading the control word returns the flag and clears it. Writing anything to the count register zeroes the count and drops the flag. Software can therefore poll the flag or take the interrupt.

Top module: `tick_timer`

## Requirements
- R1: After reset the control, reload and count registers read 0 and the interrupt request is low.
- R2: Control word at byte offset 0x0: bit 0 runs the timer, bit 1 enables the interrupt request, bit 2 selects the tick source, bit 16 is the wrap flag. Writes change only bits 2:0, and all other bits read 0.
- R3: The reload register at 0x4 holds 24 bits. Bits 31:24 read 0, and the live count at 0x8 reads in bits 23:0.
- R4: On each tick a nonzero count decrements by one, and a zero count loads the reload value, so a full period is reload+1 ticks.
- R5: Source bit 1 gives a tick on every clock while running. Source bit 0 gives one tick per 8 clocks, with the first tick on the 8th rising edge after the run bit is set.
- R6: The wrap flag sets on the tick that moves the count from 1 to 0. A read of the control word returns the flag and then clears it. A set in the same cycle as that read wins.
- R7: A write of any data to 0x8 zeroes the count and the wrap flag on that edge and suppresses that cycle's tick.
- R8: With bit 1 set, each 1-to-0 step raises the interrupt request for exactly the following clock cycle. With bit 1 clear, the flag still sets but no request is raised.
- R9: The word at 0xC reads {bit31=0, bit30=1, bits 29:24=0, bits 23:0=CAL_VALUE}, and writes to it have no effect.
- R10: With a reload value of 0, the count stays at 0 and the wrap flag never sets.
- R11: With the run bit clear, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset, deasserted in step with clk_i |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address; bits 3:2 pick the word, higher bits must be 0 |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| irq_o | output | 1 | One-cycle interrupt request pulse |

## Verification
The bench aims at the exact cycles around each zero crossing:
- A read of the control word lands one cycle before the flag sets. A design that lets the clear win would lose that wrap.
- The first divided tick is checked on the 8th edge after start, which exposes off-by-one prescaler phases.
- A count-register write is issued while the flag is pending. It must leave both the count and the flag at zero.
- Reload zero must freeze the counter without flagging.
- Running with interrupts disabled must keep the request line low while the flag still sets.
- Masked writes to control and reload must not leak into reserved bits.

// File: rtl/tick_timer_pkg.sv
`timescale 1ns/1ps
package tick_timer_pkg;

  localparam int unsigned BUS_W         = 32;
  localparam int unsigned CTRL_FLAG_BIT = 16;
  localparam int unsigned CTRL_LOW_W    = 3;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_CALIB  = 2'd3
  } reg_sel_e;

  // packed order gives bit2 = src_core, bit1 = irq_en, bit0 = run
  typedef struct packed {
    logic src_core;
    logic irq_en;
    logic run;
  } ctrl_t;

endpackage

// File: rtl/tick_prescaler.sv
`timescale 1ns/1ps
module tick_prescaler #(
  parameter int unsigned DIV_W = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_d;

  // phase restarts whenever the divided source is not in use
  always_comb begin
    if (run_i) begin
      div_d = div_q + DIV_W'(1);
    end else begin
      div_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

  assign tick_o = run_i & (&div_q);

endmodule

// File: rtl/tick_counter.sv
`timescale 1ns/1ps
module tick_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             hit_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = clear_i | tick_i;

  always_comb begin
    if (clear_i) begin
      cnt_d = '0;
    end else if (cnt_q == '0) begin
      cnt_d = reload_i;
    end else begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;
  assign hit_o   = tick_i & ~clear_i & (cnt_q == CNT_W'(1));

endmodule

// File: rtl/tick_regfile.sv
`timescale 1ns/1ps
module tick_regfile
  import tick_timer_pkg::*;
#(
  parameter int unsigned     ADDR_W    = 4,
  parameter int unsigned     CNT_W     = 24,
  parameter logic [CNT_W-1:0] CAL_VALUE = 'd22500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              hit_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              count_clr_o,
  output logic              flag_o,
  output logic              irq_o
);

  localparam int unsigned PAD_W   = BUS_W - CNT_W;
  localparam int unsigned CAL_PAD = BUS_W - 2 - CNT_W;

  reg_sel_e         sel;
  logic             in_range;
  logic             acc;
  logic             wr_ctrl, wr_reload, wr_count, rd_ctrl;
  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic             flag_q, flag_d;
  logic             irq_q, irq_d;
  logic             unused_bits;

  assign in_range  = ((bus_addr_i >> 4) == '0);
  assign sel       = reg_sel_e'(bus_addr_i[3:2]);
  assign acc       = bus_sel_i & in_range;
  assign wr_ctrl   = acc &  bus_wr_i & (sel == SEL_CTRL);
  assign wr_reload = acc &  bus_wr_i & (sel == SEL_RELOAD);
  assign wr_count  = acc &  bus_wr_i & (sel == SEL_COUNT);
  assign rd_ctrl   = acc & ~bus_wr_i & (sel == SEL_CTRL);

  assign unused_bits = ^{bus_addr_i[1:0], bus_wdata_i[BUS_W-1:CNT_W]};

  // next-state logic
  always_comb begin
    ctrl_d   = ctrl_t'(bus_wdata_i[CTRL_LOW_W-1:0]);
    reload_d = bus_wdata_i[CNT_W-1:0];
    if (hit_i) begin
      flag_d = 1'b1;
    end else if (rd_ctrl | wr_count) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag_q;
    end
    irq_d = hit_i & ctrl_q.irq_en;
  end

  // registers with explicit enables
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= ctrl_d;
      end
      if (wr_reload) begin
        reload_q <= reload_d;
      end
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    if (acc & ~bus_wr_i) begin
      unique case (sel)
        SEL_CTRL: begin
          bus_rdata_o[CTRL_LOW_W-1:0] = ctrl_q;
          bus_rdata_o[CTRL_FLAG_BIT]  = flag_q;
        end
        SEL_RELOAD: bus_rdata_o = {{PAD_W{1'b0}}, reload_q};
        SEL_COUNT:  bus_rdata_o = {{PAD_W{1'b0}}, count_i};
        SEL_CALIB:  bus_rdata_o = {1'b0, 1'b1, {CAL_PAD{1'b0}}, CAL_VALUE};
        default:    bus_rdata_o = '0;
      endcase
    end
  end

  assign ctrl_o      = ctrl_q;
  assign reload_o    = reload_q;
  assign count_clr_o = wr_count;
  assign flag_o      = flag_q;
  assign irq_o       = irq_q;

endmodule

// File: rtl/tick_timer.sv
`timescale 1ns/1ps
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned      ADDR_W    = 4,
  parameter int unsigned      CNT_W     = 24,
  parameter int unsigned      DIV_W     = 3,
  parameter logic [CNT_W-1:0] CAL_VALUE = 'd22500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o
);

  ctrl_t            ctl;
  logic             run_en;
  logic             irq_en;
  logic             pre_run;
  logic             pre_tick;
  logic             tick;
  logic             hit;
  logic             cnt_clr;
  logic             flag_val;
  logic [CNT_W-1:0] cnt_val;
  logic [CNT_W-1:0] reload_val;

  assign run_en  = ctl.run;
  assign irq_en  = ctl.irq_en;
  assign pre_run = ctl.run & ~ctl.src_core;
  assign tick    = ctl.run & (ctl.src_core | pre_tick);

  tick_prescaler #(
    .DIV_W (DIV_W)
  ) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (pre_run),
    .tick_o (pre_tick)
  );

  tick_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .clear_i  (cnt_clr),
    .reload_i (reload_val),
    .count_o  (cnt_val),
    .hit_o    (hit)
  );

  tick_regfile #(
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W),
    .CAL_VALUE (CAL_VALUE)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .count_i     (cnt_val),
    .hit_i       (hit),
    .ctrl_o      (ctl),
    .reload_o    (reload_val),
    .count_clr_o (cnt_clr),
    .flag_o      (flag_val),
    .irq_o       (irq_o)
  );

endmodule

// File: rtl/tick_timer_chk.sv
`timescale 1ns/1ps
module tick_timer_chk #(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             irq_en_i,
  input logic             tick_i,
  input logic             clr_i,
  input logic             flag_i,
  input logic             irq_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] reload_i
);

  assert_irq_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> $past(irq_en_i));

  assert_irq_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !irq_i);

  assert_flag_at_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> (cnt_i == '0));

  assert_write_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((cnt_i == '0) && !flag_i));

  assert_hold_when_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(cnt_i));

  assert_decrement_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i && (cnt_i != '0)) |=> (cnt_i == $past(cnt_i) - CNT_W'(1)));

  assert_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i && (cnt_i == '0)) |=> (cnt_i == $past(reload_i)));

  assert_zero_reload_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_i == '0) && (reload_i == '0) && !clr_i) |=> (cnt_i == '0));

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run_i    (run_en),
  .irq_en_i (irq_en),
  .tick_i   (tick),
  .clr_i    (cnt_clr),
  .flag_i   (flag_val),
  .irq_i    (irq_o),
  .cnt_i    (cnt_val),
  .reload_i (reload_val)
);

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb;

  localparam logic [31:0] CAL_WORD = 32'h4000_57E4;  // CAL_VALUE 22500
  localparam logic [3:0]  A_CTRL   = 4'h0;
  localparam logic [3:0]  A_RELOAD = 4'h4;
  localparam logic [3:0]  A_COUNT  = 4'h8;
  localparam logic [3:0]  A_CALIB  = 4'hC;

  typedef struct {
    logic [31:0] exp;
    bit          chk_irq;
    bit          exp_irq;
    string       tag;
  } sb_item_t;

  logic        clk;
  logic        rst_n;
  logic        sel;
  logic        wr;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int       total = 0;
  int       bad   = 0;
  int       irq_cnt = 0;
  bit       irq_prev = 0;
  bit       irq_wide = 0;
  bit       done = 0;
  sb_item_t sb_q[$];
  event     rd_ev;

  tick_timer u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_sel_i   (sel),
    .bus_wr_i    (wr),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    sel = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [31:0] e, input string tag,
                          input bit ci = 1'b0, input bit ei = 1'b0);
    sb_item_t it;
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    it.exp = e; it.chk_irq = ci; it.exp_irq = ei; it.tag = tag;
    sb_q.push_back(it);
    #1 -> rd_ev;
    @(posedge clk);
    #1;
    sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      sb_item_t it;
      @(rd_ev);
      it = sb_q.pop_front();
      check(rdata === it.exp, it.tag, rdata, it.exp);
      if (it.chk_irq) begin
        check(irq === it.exp_irq, {it.tag, " irq"}, {31'b0, irq}, {31'b0, it.exp_irq});
      end
    end
  end

  // interrupt pulse monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) begin
        irq_cnt++;
        if (irq_prev) irq_wide = 1'b1;
      end
      irq_prev = irq;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    #1 check(irq === 1'b0, "R1 irq low", {31'b0, irq}, 32'h0);
    bus_read(A_CTRL,   32'h0, "R1 ctrl");
    bus_read(A_RELOAD, 32'h0, "R1 reload");
    bus_read(A_COUNT,  32'h0, "R1 count");
    bus_read(A_CALIB,  CAL_WORD, "R9 calib");

    // R2 / R3 / R9 masking and read-only
    bus_write(A_CTRL, 32'hFFFF_FFF8);
    bus_read(A_CTRL, 32'h0, "R2 masked ctrl");
    bus_write(A_RELOAD, 32'hFFFF_FFFF);
    bus_read(A_RELOAD, 32'h00FF_FFFF, "R3 reload width");
    bus_write(A_CALIB, 32'h0);
    bus_read(A_CALIB, CAL_WORD, "R9 calib write ignored");

    // R4 / R6 / R8 core-clock ticks, reload 4, interrupt on
    bus_write(A_RELOAD, 32'd4);
    bus_write(A_COUNT, 32'hDEAD);
    bus_write(A_CTRL, 32'h7);
    bus_read(A_COUNT, 32'd0, "R4 before first tick");
    bus_read(A_COUNT, 32'd4, "R4 load from zero");
    bus_read(A_COUNT, 32'd3, "R4 decrement");
    bus_read(A_COUNT, 32'd2, "R5 core tick every cycle");
    bus_read(A_CTRL, 32'h0000_0007, "R6 read as flag sets", 1'b1, 1'b0);
    bus_read(A_CTRL, 32'h0001_0007, "R6 set wins over clear", 1'b1, 1'b1);
    bus_read(A_CTRL, 32'h0000_0007, "R6 cleared by read");
    bus_write(A_CTRL, 32'h5);

    // R8 interrupt off, flag still sets
    idle(10);
    bus_read(A_CTRL, 32'h0001_0005, "R8 flag without request");
    idle(10);

    // R7 count write with flag pending
    bus_write(A_COUNT, 32'h123);
    bus_read(A_COUNT, 32'd0, "R7 count zeroed");
    bus_read(A_CTRL, 32'h0000_0005, "R7 flag zeroed");
    check(irq_cnt == 1, "R8 one request only", irq_cnt, 32'd1);
    check(!irq_wide, "R8 pulse width", {31'b0, irq_wide}, 32'h0);

    // R10 zero reload freezes at zero
    bus_write(A_CTRL, 32'h0);
    bus_write(A_RELOAD, 32'd0);
    bus_write(A_COUNT, 32'd0);
    bus_write(A_CTRL, 32'h5);
    idle(10);
    bus_read(A_COUNT, 32'd0, "R10 count stays zero");
    bus_read(A_CTRL, 32'h0000_0005, "R10 no flag");

    // R5 divided source, reload 2
    bus_write(A_CTRL, 32'h0);
    bus_write(A_RELOAD, 32'd2);
    bus_write(A_COUNT, 32'd0);
    bus_write(A_CTRL, 32'h1);
    idle(7);
    bus_read(A_COUNT, 32'd0, "R5 no tick before 8th edge");
    bus_read(A_COUNT, 32'd2, "R5 tick on 8th edge");
    idle(14);
    bus_read(A_COUNT, 32'd1, "R5 next divided tick");
    bus_read(A_COUNT, 32'd0, "R5 reach zero");
    bus_read(A_CTRL, 32'h0001_0001, "R6 flag on divided source");

    // R11 stopped counter holds
    bus_write(A_CTRL, 32'h0);
    idle(10);
    bus_read(A_COUNT, 32'd0, "R11 hold while stopped");

    idle(2);
    done = 1'b1;
    finish_run();
  end

endmodule